// File: doc/BRIEF.md
# Radix-2 DIF FFT Address Sequencer

This block drives the memory side of an in-place radix-2 decimation-in-frequency FFT over N = 2^LOG2N points. A single-cycle start request launches a full transform pass. The sequencer then walks three nested loops: stages from the widest down to the narrowest, groups inside each stage, and butterflies inside each group. It does not compute any data. Its only job is to say which two memory words a butterfly unit reads and writes back, and which twiddle factor applies to them.

While a pass runs, the block presents one butterfly per clock. Each butterfly comes as a pair of data addresses and a twiddle index, qualified by a valid flag and tagged with the current stage number. When the last butterfly of the final stage has gone out, a one-cycle completion pulse follows. A datapath can consume the stream directly with no back-pressure, because the sequence never stalls.

Top module: `fft_dif_agu`

## Requirements
- R1: After reset, and whenever no pass is running, `valid` and `done` are 0.
- R2: A `start` sampled high at a clock edge while idle makes `valid` high from the next cycle. The first butterfly is addr_a = 0, addr_b = N/2, twiddle = 0, stage = LOG2N.
- R3: `stage` begins at LOG2N and falls by exactly one between stages. The last stage is 1.
- R4: Within stage s, groups have size 2^s. Group bases go 0, 2^s, 2·2^s, … up to the last one below N. Inside a group the butterfly counter k runs from 0 to 2^(s-1)−1, and addr_a = base + k.
- R5: addr_b = addr_a + 2^(s-1) in every butterfly, so bit s−1 of addr_a is always 0.
- R6: The twiddle index is 0 on the first butterfly of every group. It grows by the stage stride after each butterfly. The stride is 1 in stage LOG2N and doubles at each following stage, so the twiddle index equals k·N/2^s and stays below N/2.
- R7: `valid` stays high on consecutive cycles for exactly (N/2)·LOG2N cycles per pass, with one new butterfly per cycle.
- R8: `done` is high for exactly one cycle: the cycle right after the last valid butterfly (stage 1, last group, last butterfly). `valid` is 0 in that cycle.
- R9: A `start` that arrives while a pass is running is ignored. The running sequence continues unchanged.
- R10: After `done`, a new `start` replays the complete sequence from its first butterfly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request for one transform pass |
| valid | output | 1 | Current butterfly outputs are meaningful |
| addr_a | output | LOG2N | Address of the upper butterfly operand |
| addr_b | output | LOG2N | Address of the lower butterfly operand |
| twiddle | output | LOG2N | Twiddle-factor index, below N/2 |
| stage | output | $clog2(LOG2N+1) | Stage number, LOG2N down to 1 |
| done | output | 1 | One-cycle pulse when the pass completes |

## Verification
The bench compares every butterfly of full passes for N = 8, 16 and 64 against its own nested-loop model. A design that reset the twiddle index only per stage, and not per group, would show nonzero twiddles at the start of the second group. A design with an off-by-one in the group-end test would either run into the next stage a group early or emit addresses at or above N. The bench also checks the cycle of the completion pulse and the total valid count, which expose a final stage that is repeated or cut short. Start requests injected mid-pass and right after completion show whether a busy launch corrupts the stream and whether a legal relaunch replays it from the beginning.

// File: rtl/fft_agu_pkg.sv
package fft_agu_pkg;

  // Butterfly span (half group size) for a stage number.
  function automatic logic [31:0] span_of(input logic [7:0] stg);
    if (stg == 8'd0) return 32'd0;
    return 32'd1 << (stg - 8'd1);
  endfunction

  // Address one past the current group.
  function automatic logic [31:0] group_end(input logic [31:0] base,
                                            input logic [31:0] span);
    return base + (span << 1);
  endfunction

  // Upper operand address within a group.
  function automatic logic [31:0] upper_addr(input logic [31:0] base,
                                             input logic [31:0] k);
    return base + k;
  endfunction

  // Lower operand address, one span away from the upper one.
  function automatic logic [31:0] lower_addr(input logic [31:0] upper,
                                             input logic [31:0] span);
    return upper + span;
  endfunction

endpackage

// File: rtl/fft_agu_stage_ctl.sv
module fft_agu_stage_ctl #(
  parameter int LOG2N = 6,
  parameter int SW    = $clog2(LOG2N + 1),
  parameter int AW    = LOG2N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          grp_wrap,
  output logic          run,
  output logic [SW-1:0] stage,
  output logic [AW-1:0] stride,
  output logic          launch,
  output logic          done
);

  localparam logic [SW-1:0] TOP_STAGE = SW'(LOG2N);

  logic stage_adv;
  logic finish;

  assign launch    = start && !run;
  assign finish    = run && grp_wrap && (stage == SW'(1));
  assign stage_adv = run && grp_wrap && (stage != SW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      stage  <= '0;
      stride <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (launch) begin
        run    <= 1'b1;
        stage  <= TOP_STAGE;
        stride <= AW'(1);
      end else if (finish) begin
        run <= 1'b0;
      end else if (stage_adv) begin
        stage  <= stage - SW'(1);
        stride <= stride << 1;
      end
    end
  end

  // R8: completion pulse lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: pulse follows a running cycle and sees the pass stopped
  a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!run && $past(run)));

  // R3: stage holds or drops by one while running
  a_r3_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> (stage == $past(stage) || stage == $past(stage) - SW'(1)));

  // R3: stage never leaves 1..LOG2N during a pass
  a_r3_stage_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (stage >= SW'(1) && stage <= TOP_STAGE));

  // R9: start while busy does not reload the stage
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !grp_wrap) |=> (run && stage == $past(stage)));

endmodule

// File: rtl/fft_agu_group_walk.sv
module fft_agu_group_walk
  import fft_agu_pkg::*;
#(
  parameter int LOG2N = 6,
  parameter int SW    = $clog2(LOG2N + 1),
  parameter int AW    = LOG2N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          run,
  input  logic [SW-1:0] stage,
  input  logic [AW-1:0] stride,
  output logic [AW-1:0] span,
  output logic [AW-1:0] base,
  output logic [AW-1:0] bfly,
  output logic [AW-1:0] tw_idx,
  output logic          grp_wrap
);

  localparam logic [31:0] NPTS = 32'd1 << LOG2N;
  localparam logic [AW-1:0] HALF_N = AW'(NPTS >> 1);

  logic last_bfly;
  logic last_group;

  assign span       = AW'(span_of(8'(stage)));
  assign last_bfly  = (bfly == span - AW'(1));
  assign last_group = (group_end(32'(base), 32'(span)) == NPTS);
  assign grp_wrap   = run && last_bfly && last_group;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base   <= '0;
      bfly   <= '0;
      tw_idx <= '0;
    end else if (launch || grp_wrap) begin
      base   <= '0;
      bfly   <= '0;
      tw_idx <= '0;
    end else if (run && last_bfly) begin
      base   <= AW'(group_end(32'(base), 32'(span)));
      bfly   <= '0;
      tw_idx <= '0;
    end else if (run) begin
      bfly   <= bfly + AW'(1);
      tw_idx <= tw_idx + stride;
    end
  end

  // R6: each group opens with twiddle index 0
  a_r6_tw_group_start: assert property (@(posedge clk) disable iff (!rst_n)
    (run && bfly == '0) |-> (tw_idx == '0));

  // R6: twiddle index stays below N/2
  a_r6_tw_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (tw_idx < HALF_N));

  // R4: butterfly counter stays inside the group
  a_r4_bfly_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (bfly < span));

endmodule

// File: rtl/fft_agu_addr_out.sv
module fft_agu_addr_out
  import fft_agu_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] bfly,
  input  logic [AW-1:0] span,
  input  logic [AW-1:0] tw_idx,
  output logic          valid,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [AW-1:0] twiddle
);

  assign valid   = run;
  assign addr_a  = AW'(upper_addr(32'(base), 32'(bfly)));
  assign addr_b  = AW'(lower_addr(32'(addr_a), 32'(span)));
  assign twiddle = tw_idx;

  // R5: upper operand never has the span bit set, lower one always has it
  a_r5_pair_split: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (((addr_a & span) == '0) && ((addr_b & span) == span)));

  // R5: lower operand lies above the upper one
  a_r5_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (addr_b > addr_a));

endmodule

// File: rtl/fft_dif_agu.sv
module fft_dif_agu #(
  parameter int LOG2N = 6,
  localparam int AW   = LOG2N,
  localparam int SW   = $clog2(LOG2N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          valid,
  output logic [AW-1:0] addr_a,
  output logic [AW-1:0] addr_b,
  output logic [AW-1:0] twiddle,
  output logic [SW-1:0] stage,
  output logic          done
);

  logic          run;
  logic          launch;
  logic          grp_wrap;
  logic [AW-1:0] stride;
  logic [AW-1:0] span;
  logic [AW-1:0] base;
  logic [AW-1:0] bfly;
  logic [AW-1:0] tw_idx;

  fft_agu_stage_ctl #(.LOG2N(LOG2N), .SW(SW), .AW(AW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .grp_wrap (grp_wrap),
    .run      (run),
    .stage    (stage),
    .stride   (stride),
    .launch   (launch),
    .done     (done)
  );

  fft_agu_group_walk #(.LOG2N(LOG2N), .SW(SW), .AW(AW)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .run      (run),
    .stage    (stage),
    .stride   (stride),
    .span     (span),
    .base     (base),
    .bfly     (bfly),
    .tw_idx   (tw_idx),
    .grp_wrap (grp_wrap)
  );

  fft_agu_addr_out #(.AW(AW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .base    (base),
    .bfly    (bfly),
    .span    (span),
    .tw_idx  (tw_idx),
    .valid   (valid),
    .addr_a  (addr_a),
    .addr_b  (addr_b),
    .twiddle (twiddle)
  );

  // R1: idle block shows no activity
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !valid);

  // R2: an idle start produces valid output on the next cycle
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !valid) |=> valid);

endmodule

// File: tb/fft_dif_agu_test.sv
module fft_dif_agu_test;

  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;

  logic       start_v [3];
  logic       vld [3];
  logic       dn [3];
  logic [5:0] a0 [3];
  logic [5:0] a1 [3];
  logic [5:0] tw [3];
  logic [2:0] stg [3];

  logic [2:0] u8_a0, u8_a1, u8_tw;
  logic [1:0] u8_st;
  logic [3:0] u16_a0, u16_a1, u16_tw;
  logic [2:0] u16_st;
  logic [5:0] u64_a0, u64_a1, u64_tw;
  logic [2:0] u64_st;

  fft_dif_agu #(.LOG2N(3)) uut (
    .clk(clk), .rst_n(rst_n), .start(start_v[0]), .valid(vld[0]),
    .addr_a(u8_a0), .addr_b(u8_a1), .twiddle(u8_tw), .stage(u8_st), .done(dn[0]));

  fft_dif_agu #(.LOG2N(4)) uut16 (
    .clk(clk), .rst_n(rst_n), .start(start_v[1]), .valid(vld[1]),
    .addr_a(u16_a0), .addr_b(u16_a1), .twiddle(u16_tw), .stage(u16_st), .done(dn[1]));

  fft_dif_agu #(.LOG2N(6)) uut64 (
    .clk(clk), .rst_n(rst_n), .start(start_v[2]), .valid(vld[2]),
    .addr_a(u64_a0), .addr_b(u64_a1), .twiddle(u64_tw), .stage(u64_st), .done(dn[2]));

  assign a0[0]  = {3'b0, u8_a0};
  assign a1[0]  = {3'b0, u8_a1};
  assign tw[0]  = {3'b0, u8_tw};
  assign stg[0] = {1'b0, u8_st};
  assign a0[1]  = {2'b0, u16_a0};
  assign a1[1]  = {2'b0, u16_a1};
  assign tw[1]  = {2'b0, u16_tw};
  assign stg[1] = u16_st;
  assign a0[2]  = u64_a0;
  assign a1[2]  = u64_a1;
  assign tw[2]  = u64_tw;
  assign stg[2] = u64_st;

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R1: quiet outputs after reset
  task automatic t_reset();
    for (int i = 0; i < 3; i++) begin
      chk("R1", "valid after reset", int'(vld[i]), 0);
      chk("R1", "done after reset", int'(dn[i]), 0);
    end
  endtask

  // Full pass compared against a nested-loop model; poke_at injects a busy start.
  task automatic t_sweep(input int sel, input int lg, input int poke_at);
    int n = 1 << lg;
    int idx = 0;
    int vcount = 0;
    @(negedge clk) start_v[sel] = 1'b1;
    @(negedge clk) start_v[sel] = 1'b0;
    for (int s = lg; s >= 1; s--) begin
      int m = 1 << s;
      int span = m / 2;
      int stride = n >> s;
      for (int g = 0; g < n; g += m) begin
        for (int k = 0; k < span; k++) begin
          if (vld[sel]) vcount++;
          chk("R7", "valid in pass", int'(vld[sel]), 1);
          chk("R3", "stage", int'(stg[sel]), s);
          chk("R4", "addr_a", int'(a0[sel]), g + k);
          chk("R5", "addr_b", int'(a1[sel]), g + k + span);
          chk("R6", "twiddle", int'(tw[sel]), k * stride);
          chk("R8", "done early", int'(dn[sel]), 0);
          if (idx == poke_at) start_v[sel] = 1'b1; // R9: busy start
          idx++;
          @(negedge clk);
          start_v[sel] = 1'b0;
        end
      end
    end
    chk("R7", "valid cycle total", vcount, (n / 2) * lg);
    chk("R8", "valid after pass", int'(vld[sel]), 0);
    chk("R8", "done pulse", int'(dn[sel]), 1);
    @(negedge clk);
    chk("R8", "done width", int'(dn[sel]), 0);
    chk("R1", "idle valid", int'(vld[sel]), 0);
  endtask

  // R2: first butterfly right after launch
  task automatic t_first(input int sel, input int lg);
    int n = 1 << lg;
    @(negedge clk) start_v[sel] = 1'b1;
    @(negedge clk) start_v[sel] = 1'b0;
    chk("R2", "valid", int'(vld[sel]), 1);
    chk("R2", "addr_a", int'(a0[sel]), 0);
    chk("R2", "addr_b", int'(a1[sel]), n / 2);
    chk("R2", "twiddle", int'(tw[sel]), 0);
    chk("R2", "stage", int'(stg[sel]), lg);
    // drain the rest of the pass: (N/2)*lg valid cycles in total
    for (int c = 1; c < (n / 2) * lg; c++) @(negedge clk);
    @(negedge clk);
    chk("R2", "done at end", int'(dn[sel]), 1);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) start_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_first(0, 3);
    t_sweep(0, 3, -1);
    t_sweep(0, 3, -1);   // R10: replay after done
    t_sweep(1, 4, 5);    // R9: start mid-pass
    t_sweep(2, 6, 100);  // R9: start inside a later stage
    t_first(2, 6);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule